// File: doc/BRIEF.md
# Debug Run-Control Unit

This block sits on the debug side of an embedded processor. An external debug host uses it to stop the CPU, let it run, advance it one instruction at a time, hold it in reset, and learn why it stopped. The host reaches two registers over a small register bus. The command register sits at address 0 and the event/status register at address 1. Writes take effect on the clock edge that samples `bus_wr`. Reads are combinational from `bus_addr`.

On the CPU side the unit watches three inputs: a strobe that marks each completed instruction, a flag raised when the CPU fetches its breakpoint opcode, and the core's own "halted" indication. It drives four outputs: a level halt request, a single-step release that stays high until one instruction has completed, a peripheral freeze that is active only while the CPU is actually halted, and a CPU reset. Break-on-reset arms the halt request while the CPU is still in reset, so the core leaves reset already stopped.

Top module: `rc_dbg_runctl`

## Requirements
- R1: Command register (address 0) bit layout: bit3 = breakpoint enable, bit4 = freeze-when-halted, bit5 = break-on-reset, bit6 = CPU reset. These bits are stored on a write and read back as written. The one-shot command bits 0 (halt), 1 (run) and 2 (step) always read 0. All other bits of both registers read 0 and ignore writes. Reads from an address other than 0 or 1 return 0.
- R2: `cpu_rst_o` goes high on the edge after a command write with bit6 = 1. It stays high until a command write with bit6 = 0.
- R3: A command write with bit0 = 1, made outside CPU reset, sets `halt_req_o` on that edge. Status bit0 reads 1 exactly when `halt_req_o` and `cpu_halted` are both high.
- R4: A command write with only bit1 set among bits 0..2, made outside reset and with no breakpoint hit in that cycle, clears `halt_req_o` on that edge. Status bit0 therefore reads 0 on the cycle after the write.
- R5: A command write with bit2 = 1 while `halt_req_o` is high and `step_o` is low raises `step_o` on that edge. `step_o` falls on the edge after the first `cpu_insn_done` it sees, so exactly one instruction completes per step. A step command is ignored while `halt_req_o` is low.
- R6: When several one-shot bits are written together, halt beats step and step beats run. A step command never clears `halt_req_o`.
- R7: `freeze_o` is high only while `cpu_halted` is high and command bit4 is 1.
- R8: Status bit2 is a sticky CPU-reset event. It is set on every edge at which `cpu_rst_o` was high.
- R9: While `cpu_rst_o` is high, `halt_req_o` follows break-on-reset (the incoming value of bit5 on a command write, otherwise the stored value). With bit5 set, the CPU leaves reset halted and status reads 0x0005.
- R10: With bit3 = 1 and outside reset, a `cpu_brk_fetch` sets `halt_req_o` and the sticky status bit3. Status then reads 0x000D after a reset plus a breakpoint, and 0x0009 after a breakpoint alone. With bit3 = 0 the fetch has no effect.
- R11: Writing 1 to status bit2 or bit3 (address 1) clears it, unless the event recurs in the same cycle, in which case the event wins. Status writes cannot change bit0. Writing 0x00FF to a running CPU's status leaves it at 0x0000.
- R12: After reset all outputs are 0 and both registers read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register select (0 command, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| cpu_insn_done | input | 1 | Instruction-completed strobe from the CPU |
| cpu_brk_fetch | input | 1 | CPU fetched the breakpoint opcode |
| cpu_halted | input | 1 | CPU reports it is halted |
| halt_req_o | output | 1 | Halt request to the CPU |
| step_o | output | 1 | Single-step release, held until one instruction completes |
| freeze_o | output | 1 | Peripheral freeze |
| cpu_rst_o | output | 1 | CPU reset |

## Verification
The hardest state to reach from the ports is the hand-off at the end of CPU reset. The releasing write must arm the halt from its own bit5 while the stored reset bit is still high. The sticky reset event must also survive a clear written during reset. The stimulus first holds the CPU in reset and writes a clear that the event must override. It then releases reset once with break-on-reset carried in the same write and once without it. A behavioural CPU model drives `cpu_halted` and `cpu_insn_done` from the unit's own outputs, so single steps finish on real instruction strobes. Combined one-shot writes (halt+step+run, step+run) are applied while halted.

// File: rtl/rc_pkg.sv
package rc_pkg;

  // command register bit positions (decoded by the host software)
  localparam int unsigned CTL_HALT  = 0;
  localparam int unsigned CTL_RUN   = 1;
  localparam int unsigned CTL_STEP  = 2;
  localparam int unsigned CTL_BRKEN = 3;
  localparam int unsigned CTL_FRZ   = 4;
  localparam int unsigned CTL_BOR   = 5;
  localparam int unsigned CTL_CRST  = 6;
  localparam int unsigned CTL_USED  = CTL_CRST + 1;

  // status register bit positions
  localparam int unsigned ST_HALTED = 0;
  localparam int unsigned ST_RSTEV  = 2;
  localparam int unsigned ST_BRKEV  = 3;

  typedef struct packed {
    logic halt;
    logic run;
    logic step;
  } cmd_t;

  typedef struct packed {
    logic crst;
    logic bor;
    logic frz;
    logic brk_en;
  } lvl_t;

endpackage

// File: rtl/rc_rst_sync.sv
module rc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rc_ctl_regs.sv
module rc_ctl_regs
  import rc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [CTL_USED-1:0] wbits,
  output cmd_t                cmd,
  output lvl_t                lvl_q,
  output logic                bor_eff,
  output logic [DATA_W-1:0]   ctl_rdata
);

  lvl_t lvl_d;
  logic lvl_en;

  // one-shot commands exist only in the cycle of the write
  always_comb begin
    cmd = '0;
    if (wr_hit) begin
      cmd.halt = wbits[CTL_HALT];
      cmd.run  = wbits[CTL_RUN];
      cmd.step = wbits[CTL_STEP];
    end
  end

  always_comb begin
    lvl_en       = wr_hit;
    lvl_d.crst   = wbits[CTL_CRST];
    lvl_d.bor    = wbits[CTL_BOR];
    lvl_d.frz    = wbits[CTL_FRZ];
    lvl_d.brk_en = wbits[CTL_BRKEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  // break-on-reset as seen by the releasing write itself
  assign bor_eff = wr_hit ? wbits[CTL_BOR] : lvl_q.bor;

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[CTL_BRKEN] = lvl_q.brk_en;
    ctl_rdata[CTL_FRZ]   = lvl_q.frz;
    ctl_rdata[CTL_BOR]   = lvl_q.bor;
    ctl_rdata[CTL_CRST]  = lvl_q.crst;
  end

  // R1
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(lvl_q));

endmodule

// File: rtl/rc_run_fsm.sv
module rc_run_fsm
  import rc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  lvl_t lvl_q,
  input  logic bor_eff,
  input  logic brk_fetch,
  input  logic insn_done,
  output logic halt_req,
  output logic step_act,
  output logic brk_hit
);

  logic halt_d;
  logic step_d;

  assign brk_hit = brk_fetch && lvl_q.brk_en && !lvl_q.crst;

  always_comb begin
    halt_d = halt_req;
    step_d = step_act;
    if (lvl_q.crst) begin
      halt_d = bor_eff;
      step_d = 1'b0;
    end else begin
      if (cmd.halt)      halt_d = 1'b1;
      else if (brk_hit)  halt_d = 1'b1;
      else if (cmd.step) halt_d = halt_req;
      else if (cmd.run)  halt_d = 1'b0;

      if (step_act)      step_d = !insn_done;
      else               step_d = cmd.step && !cmd.halt && halt_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      step_act <= 1'b0;
    end else begin
      halt_req <= halt_d;
      step_act <= step_d;
    end
  end

  // R3
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.halt && !lvl_q.crst) |=> halt_req);

  // R4
  run_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.run && !cmd.halt && !cmd.step && !brk_hit && !lvl_q.crst) |=> !halt_req);

  // R5
  step_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_act && insn_done) |=> !step_act);

  // R5
  step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_act) |-> $past(halt_req));

  // R6
  halt_over_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.halt && !step_act) |=> !step_act);

  // R9
  bor_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q.crst |=> (halt_req == $past(bor_eff)));

endmodule

// File: rtl/rc_status.sv
module rc_status
  import rc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              clr_rst,
  input  logic              clr_brk,
  input  logic              in_reset,
  input  logic              brk_hit,
  input  logic              halted_now,
  output logic [DATA_W-1:0] stat_rdata
);

  logic rst_ev_q, rst_ev_d;
  logic brk_ev_q, brk_ev_d;

  // event wins over a clear in the same cycle
  always_comb begin
    rst_ev_d = (rst_ev_q && !(wr_hit && clr_rst)) || in_reset;
    brk_ev_d = (brk_ev_q && !(wr_hit && clr_brk)) || brk_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ev_q <= 1'b0;
      brk_ev_q <= 1'b0;
    end else begin
      rst_ev_q <= rst_ev_d;
      brk_ev_q <= brk_ev_d;
    end
  end

  always_comb begin
    stat_rdata            = '0;
    stat_rdata[ST_HALTED] = halted_now;
    stat_rdata[ST_RSTEV]  = rst_ev_q;
    stat_rdata[ST_BRKEV]  = brk_ev_q;
  end

  // R8
  rst_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> rst_ev_q);

  // R10
  brk_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> brk_ev_q);

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ev_q && !wr_hit) |=> rst_ev_q);

endmodule

// File: rtl/rc_dbg_runctl.sv
module rc_dbg_runctl
  import rc_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 1,
  parameter int unsigned CTL_ADDR   = 0,
  parameter int unsigned STAT_ADDR  = 1,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cpu_insn_done,
  input  logic              cpu_brk_fetch,
  input  logic              cpu_halted,
  output logic              halt_req_o,
  output logic              step_o,
  output logic              freeze_o,
  output logic              cpu_rst_o
);

  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic              srst_n;
  logic              ctl_hit, stat_hit;
  cmd_t              cmd;
  lvl_t              lvl_q;
  logic              bor_eff;
  logic              brk_hit;
  logic              halted_now;
  logic [DATA_W-1:0] ctl_rdata, stat_rdata;
  logic              unused_wbits;

  assign ctl_hit      = bus_wr && (bus_addr == CTL_A);
  assign stat_hit     = bus_wr && (bus_addr == STAT_A);
  assign unused_wbits = ^bus_wdata[DATA_W-1:CTL_USED];

  rc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rc_ctl_regs #(.DATA_W(DATA_W)) u_ctl (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_hit    (ctl_hit),
    .wbits     (bus_wdata[CTL_USED-1:0]),
    .cmd       (cmd),
    .lvl_q     (lvl_q),
    .bor_eff   (bor_eff),
    .ctl_rdata (ctl_rdata)
  );

  rc_run_fsm u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .cmd       (cmd),
    .lvl_q     (lvl_q),
    .bor_eff   (bor_eff),
    .brk_fetch (cpu_brk_fetch),
    .insn_done (cpu_insn_done),
    .halt_req  (halt_req_o),
    .step_act  (step_o),
    .brk_hit   (brk_hit)
  );

  assign halted_now = halt_req_o && cpu_halted;

  rc_status #(.DATA_W(DATA_W)) u_stat (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_hit     (stat_hit),
    .clr_rst    (bus_wdata[ST_RSTEV]),
    .clr_brk    (bus_wdata[ST_BRKEV]),
    .in_reset   (lvl_q.crst),
    .brk_hit    (brk_hit),
    .halted_now (halted_now),
    .stat_rdata (stat_rdata)
  );

  assign cpu_rst_o = lvl_q.crst;
  assign freeze_o  = cpu_halted && lvl_q.frz;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTL_A)       bus_rdata = ctl_rdata;
    else if (bus_addr == STAT_A) bus_rdata = stat_rdata;
  end

  // R2
  crst_cause_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cpu_rst_o) |-> $past(ctl_hit && bus_wdata[CTL_CRST]));

  // R7
  freeze_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(freeze_o) |-> (cpu_halted && cpu_rst_o == 1'b0 || cpu_halted));

endmodule

// File: tb/tb_rc_dbg_runctl.sv
module tb_rc_dbg_runctl;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [0:0]  bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_insn_done = 1'b0;
  logic        cpu_brk_fetch = 1'b0;
  logic        cpu_halted = 1'b0;
  logic        halt_req_o, step_o, freeze_o, cpu_rst_o;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int cpu_phase = 0;
  int step_rises = 0;
  int step_insns = 0;
  bit prev_step = 1'b0;

  // reference model state
  bit m_brk, m_frz, m_bor, m_rst, m_halt, m_step, m_rf, m_bf;

  rc_dbg_runctl dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .cpu_insn_done (cpu_insn_done),
    .cpu_brk_fetch (cpu_brk_fetch),
    .cpu_halted    (cpu_halted),
    .halt_req_o    (halt_req_o),
    .step_o        (step_o),
    .freeze_o      (freeze_o),
    .cpu_rst_o     (cpu_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model, advanced on each edge from the bench-driven inputs
  always @(posedge clk) begin
    bit cw, sw, hit;
    bit n_halt, n_step, n_rf, n_bf;
    if (!rst_n) begin
      {m_brk, m_frz, m_bor, m_rst, m_halt, m_step, m_rf, m_bf} = '0;
    end else begin
      cw  = bus_wr && bus_addr == 1'b0;
      sw  = bus_wr && bus_addr == 1'b1;
      hit = cpu_brk_fetch && m_brk && !m_rst;
      n_halt = m_halt;
      n_step = m_step;
      if (m_rst) begin
        n_halt = cw ? bus_wdata[5] : m_bor;
        n_step = 1'b0;
      end else begin
        if (cw && bus_wdata[0])      n_halt = 1'b1;
        else if (hit)                n_halt = 1'b1;
        else if (cw && bus_wdata[2]) n_halt = m_halt;
        else if (cw && bus_wdata[1]) n_halt = 1'b0;
        if (m_step) n_step = !cpu_insn_done;
        else        n_step = cw && bus_wdata[2] && !bus_wdata[0] && m_halt;
      end
      n_rf = (m_rf && !(sw && bus_wdata[2])) || m_rst;
      n_bf = (m_bf && !(sw && bus_wdata[3])) || hit;
      if (cw) {m_rst, m_bor, m_frz, m_brk} = bus_wdata[6:3];
      m_halt = n_halt;
      m_step = n_step;
      m_rf   = n_rf;
      m_bf   = n_bf;
    end
  end

  function automatic logic [15:0] exp_rdata();
    logic [15:0] v = '0;
    if (bus_addr == 1'b0) v[6:3] = {m_rst, m_bor, m_frz, m_brk};
    else v[3:0] = {m_bf, m_rf, 1'b0, m_halt && cpu_halted};
    return v;
  endfunction

  task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: got %h expected %h", tag, cycles, got, exp);
    end
  endtask

  // every-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(QTR);
    cycles++;
    cmp("R3/R4/R9 halt_req_o", {15'b0, halt_req_o}, {15'b0, m_halt});
    cmp("R5 step_o",           {15'b0, step_o},     {15'b0, m_step});
    cmp("R2 cpu_rst_o",        {15'b0, cpu_rst_o},  {15'b0, m_rst});
    cmp("R7 freeze_o",         {15'b0, freeze_o},   {15'b0, cpu_halted && m_frz});
    cmp("R1/R11 bus_rdata",    bus_rdata,           exp_rdata());
    if (prev_step && cpu_insn_done) step_insns++;
    if (step_o && !prev_step) step_rises++;
    prev_step = step_o;
    if (cycles > WDOG_LIMIT) begin
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // behavioural CPU: halts when requested, completes an instruction every third cycle
  always @(negedge clk) begin
    bit run_ok;
    if (!rst_n || cpu_rst_o) begin
      cpu_halted    <= 1'b0;
      cpu_insn_done <= 1'b0;
      cpu_phase     = 0;
    end else begin
      run_ok        = !halt_req_o || step_o;
      cpu_phase     = (cpu_phase + 1) % 3;
      cpu_halted    <= !run_ok;
      cpu_insn_done <= run_ok && cpu_phase == 2;
    end
  end

  task automatic wr(input bit a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input bit a, input logic [15:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #(QTR);
    cmp(tag, bus_rdata, e);
  endtask

  task automatic brk_pulse();
    @(negedge clk);
    cpu_brk_fetch = 1'b1;
    @(negedge clk);
    cpu_brk_fetch = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    @(posedge clk);
    #(QTR);
    cmp(tag, {15'b0, got}, {15'b0, exp});
  endtask

  initial begin
    int r0, s0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R12 reset state
    rd(1'b0, 16'h0000, "R12 ctl after reset");
    rd(1'b1, 16'h0000, "R12 status after reset");
    chk1("R12 outputs idle", halt_req_o | step_o | freeze_o | cpu_rst_o, 1'b0);

    // R11 all-ones status write on a running CPU
    wr(1'b1, 16'h00FF);
    rd(1'b1, 16'h0000, "R11 status after 0xFF write");

    // R3 halt
    wr(1'b0, 16'h0001);
    idle(3);
    rd(1'b1, 16'h0001, "R3 halted status");
    chk1("R7 freeze low with bit4 clear", freeze_o, 1'b0);

    // R7 freeze + R1 readback
    wr(1'b0, 16'h0011);
    idle(3);
    chk1("R7 freeze while halted", freeze_o, 1'b1);
    rd(1'b0, 16'h0010, "R1 ctl readback");

    // R5 single steps
    r0 = step_rises;
    s0 = step_insns;
    for (int k = 0; k < 3; k++) begin
      wr(1'b0, 16'h0014);
      idle(8);
    end
    chk1("R5 three steps issued", step_rises == r0 + 3, 1'b1);
    chk1("R5 one insn per step", step_insns == s0 + 3, 1'b1);
    chk1("R5 halted after steps", halt_req_o, 1'b1);

    // R6 priority
    r0 = step_rises;
    wr(1'b0, 16'h0017);
    idle(6);
    chk1("R6 halt beats step and run", step_rises == r0 && halt_req_o, 1'b1);
    wr(1'b0, 16'h0016);
    idle(8);
    chk1("R6 step beats run", step_rises == r0 + 1 && halt_req_o, 1'b1);

    // R4 run
    wr(1'b0, 16'h0002);
    rd(1'b1, 16'h0000, "R4 status right after run");
    chk1("R7 freeze low when running", freeze_o, 1'b0);

    // R5 step ignored while running
    r0 = step_rises;
    wr(1'b0, 16'h0004);
    idle(4);
    chk1("R5 step ignored when running", step_rises == r0 && !halt_req_o, 1'b1);

    // R2 / R8 / R11 reset
    wr(1'b0, 16'h0040);
    rd(1'b1, 16'h0004, "R8 reset event");
    chk1("R2 cpu reset held", cpu_rst_o, 1'b1);
    wr(1'b1, 16'h0004);
    rd(1'b1, 16'h0004, "R11 event wins over clear");
    wr(1'b0, 16'h0000);
    rd(1'b1, 16'h0004, "R8 sticky after release");
    chk1("R2 cpu reset released", cpu_rst_o, 1'b0);
    wr(1'b1, 16'h0004);
    rd(1'b1, 16'h0000, "R11 clear reset event");

    // R9 break on reset, armed before and in the releasing write
    wr(1'b0, 16'h0060);
    rd(1'b1, 16'h0004, "R9 status during reset");
    wr(1'b0, 16'h0020);
    idle(2);
    rd(1'b1, 16'h0005, "R9 leaves reset halted");
    wr(1'b1, 16'h0004);
    rd(1'b1, 16'h0001, "R11 halt bit survives clear");
    wr(1'b0, 16'h0002);
    wr(1'b0, 16'h0040);
    wr(1'b0, 16'h0020);
    idle(2);
    chk1("R9 bit5 carried in releasing write", halt_req_o, 1'b1);
    wr(1'b1, 16'h0004);
    wr(1'b0, 16'h0002);

    // R10 breakpoint disabled
    brk_pulse();
    rd(1'b1, 16'h0000, "R10 fetch ignored when disabled");

    // R10 breakpoint after reset
    wr(1'b0, 16'h0048);
    wr(1'b0, 16'h0008);
    idle(2);
    brk_pulse();
    idle(1);
    rd(1'b1, 16'h000D, "R10 reset plus breakpoint");
    wr(1'b1, 16'h000C);
    rd(1'b1, 16'h0001, "R11 clear both events");
    wr(1'b0, 16'h000A);
    idle(3);
    brk_pulse();
    idle(1);
    rd(1'b1, 16'h0009, "R10 breakpoint alone");

    // R1 reserved bits
    wr(1'b0, 16'hFF80);
    rd(1'b0, 16'h0000, "R1 reserved ctl bits");
    wr(1'b1, 16'hFFF0);
    rd(1'b1, 16'h0009, "R11 reserved status bits");

    idle(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule